// File: doc/BRIEF.md
# SCSI Host Adapter DMA Register Block

This block is the bus-slave register file of a SCSI host adapter. It sits between the host bus and two neighbours: a bus-interface controller with eight byte-wide registers, and a DMA engine with its FIFO. It decodes a 32-byte register window that repeats across a 2 KB region. It forwards controller accesses to the controller. It keeps the DMA address, the shared DMA/FIFO transfer count, the interrupt vector and address modifier, and a 16-bit control/status word.

The status word brings together the live DMA and FIFO status, two sticky error flags and six control bits. The two reset controls in the status word are active low. One request line combines every interrupt source. The controller's own interrupt passes to that line only while DMA is enabled. Idle software therefore clears the count and then sets the enable, so that reselection can still interrupt. Any controller access while DMA is enabled is flagged as a conflict.

Top module: `scsi_adapter_regs`

## Requirements
- R1: The block responds (`busHit`=1) only when a read or write is active and address bits [15:11] are zero, so offset 0x800 gets no response. Address bits [10:5] are ignored, so the 32-byte window repeats.
- R2: Window offsets 0x00–0x07 go to the controller. `ctlSel` and `ctlWr`/`ctlRd` are raised in the same cycle, with `ctlIdx` equal to address[2:0] and `ctlWdata` equal to write data [7:0]. A read returns {8'h00, `ctlRdata`}.
- R3: The DMA address high word is at 0x08 and holds bits [23:16]; it reads back zero-extended. The low word is at 0x0A. Both reset to 0 and drive `dmaAddr`.
- R4: The transfer count is shared. A write to 0x0C or 0x1A sets count bits [23:16], and a write to 0x0E or 0x10 sets bits [15:0]. Each address of a pair reads the value written through the other. Between writes, the count holds.
- R5: The status word at 0x12 reads {active[15], conflict[14], bus error[13], board id[12], FIFO full[11], FIFO empty[10], controller irq[9], DMA irq[8], left-over count[7:6], control[5:0]}. Writes to bits 15:6 have no effect.
- R6: The control bits are: [5] byte-pack control, [4] DMA enable, [3] send direction, [2] interrupt enable, [1] FIFO reset (active low), [0] controller/DMA reset (active low). They are written from data bits 5:0, reset to 0 (both resets asserted), and drive their output pins.
- R7: A controller access while DMA enable is 1 sets the conflict flag. The same access with DMA enable at 0 does not set it.
- R8: The conflict flag and the bus-error flag (set by a `dmaBusErrIn` pulse) stay set through status writes that have bit 0 = 1. A status write with bit 0 = 0 clears both.
- R9: The vector/modifier word at 0x18 stores bits 13:0 (vector 7:0, modifier 13:8) and reads bits 15:14 as 0.
- R10: `irqOut` is registered. One cycle after any state, it equals interrupt enable AND (gated controller irq OR DMA irq OR conflict OR bus error).
- R11: With DMA enable at 0, a pending controller interrupt alone never raises `irqOut`.
- R12: Offsets 0x1C and 0x1E read 0 and ignore writes. The byte-pack words at 0x14/0x16 return `packHiIn`/`packLoIn`, and writes out of region change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Host byte address |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busWdata | input | 16 | Host write data |
| busRdata | output | 16 | Host read data, valid in the read cycle |
| busHit | output | 1 | Access falls in this block's region |
| ctlSel | output | 1 | Controller register access |
| ctlWr | output | 1 | Controller write |
| ctlRd | output | 1 | Controller read |
| ctlIdx | output | 3 | Controller register index |
| ctlWdata | output | 8 | Controller write data |
| ctlRdata | input | 8 | Controller read data |
| ctlIrqIn | input | 1 | Controller interrupt pending |
| dmaIrqIn | input | 1 | DMA interrupt pending |
| dmaBusErrIn | input | 1 | DMA bus error pulse |
| dmaActiveIn | input | 1 | DMA transfer in progress |
| fifoFullIn | input | 1 | FIFO full |
| fifoEmptyIn | input | 1 | FIFO empty |
| lobCountIn | input | 2 | Left-over byte count |
| packHiIn | input | 16 | Byte-pack high word |
| packLoIn | input | 16 | Byte-pack low word |
| dmaAddr | output | 24 | DMA address |
| dmaCount | output | 24 | Shared DMA/FIFO count |
| vecOut | output | 8 | Interrupt vector |
| addrModOut | output | 6 | Bus address modifier |
| packCtlOut | output | 1 | Byte-pack control |
| dmaEnOut | output | 1 | DMA enable |
| sendOut | output | 1 | Send direction |
| fifoResetN | output | 1 | FIFO reset, active low |
| ctlResetN | output | 1 | Controller/DMA reset, active low |
| irqOut | output | 1 | Interrupt request |

## Verification
Read data and the controller strobes are combinational, so they are due in the same cycle as the access. The bench samples them 1 ns after driving at the falling edge. Register contents, the status flags and the control outputs change at the first rising edge of a write or pulse, so they are checked by a later read. `irqOut` adds one more register, so it is due at the second rising edge after its cause. The bench waits two full cycles before it samples the request line.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int REG_W   = 16;
  localparam int WIN_BITS = 5;

  // word index (address[4:1]) of each 16-bit register in the window
  localparam logic [3:0] W_ADDR_HI = 4'd4;
  localparam logic [3:0] W_ADDR_LO = 4'd5;
  localparam logic [3:0] W_CNT_HI  = 4'd6;
  localparam logic [3:0] W_CNT_LO  = 4'd7;
  localparam logic [3:0] W_FCNT_LO = 4'd8;
  localparam logic [3:0] W_CSR     = 4'd9;
  localparam logic [3:0] W_PACK_HI = 4'd10;
  localparam logic [3:0] W_PACK_LO = 4'd11;
  localparam logic [3:0] W_VECMOD  = 4'd12;
  localparam logic [3:0] W_FCNT_HI = 4'd13;

  // control bit positions inside the status word
  localparam int B_CTLRSTN  = 0;
  localparam int B_FIFORSTN = 1;
  localparam int B_INTEN    = 2;
  localparam int B_SEND     = 3;
  localparam int B_DMAEN    = 4;
  localparam int B_PACK     = 5;
  localparam int RW_W       = 6;
  localparam int VM_W       = 14;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTL, SEL_ADDR_HI, SEL_ADDR_LO, SEL_CNT_HI, SEL_CNT_LO,
    SEL_CSR, SEL_PACK_HI, SEL_PACK_LO, SEL_VECMOD
  } reg_sel_e;

  typedef struct packed {
    logic     wrAddrHi;
    logic     wrAddrLo;
    logic     wrCntHi;
    logic     wrCntLo;
    logic     wrCsr;
    logic     wrVecMod;
    logic     setConflict;
    reg_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/sar_decode.sv
module sar_decode
  import sar_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REGION_BITS = 11,
  parameter int REGION_TAG  = 0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              dmaEn,
  output logic              busHit,
  output logic              ctlSel,
  output logic              ctlWr,
  output logic              ctlRd,
  output logic [2:0]        ctlIdx,
  output strobe_t           stb
);
  localparam int TAG_W = ADDR_W - REGION_BITS;

  logic [WIN_BITS-1:0] winOff;
  logic [3:0]          wordIdx;
  logic                tagOk;
  logic                inCtl;
  logic                unusedAliasBits;

  assign winOff  = busAddr[WIN_BITS-1:0];
  assign wordIdx = winOff[4:1];
  assign tagOk   = busAddr[ADDR_W-1:REGION_BITS] == TAG_W'(REGION_TAG);
  assign inCtl   = winOff[4:3] == 2'b00;
  assign unusedAliasBits = ^busAddr[REGION_BITS-1:WIN_BITS];

  assign busHit = tagOk & (busWr | busRd);
  assign ctlSel = busHit & inCtl;
  assign ctlWr  = ctlSel & busWr;
  assign ctlRd  = ctlSel & busRd;
  assign ctlIdx = winOff[2:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    if (busHit) begin
      if (inCtl) begin
        stb.rdSel       = SEL_CTL;
        stb.setConflict = dmaEn;
      end else begin
        case (wordIdx)
          W_ADDR_HI: begin stb.rdSel = SEL_ADDR_HI; stb.wrAddrHi = busWr; end
          W_ADDR_LO: begin stb.rdSel = SEL_ADDR_LO; stb.wrAddrLo = busWr; end
          W_CNT_HI, W_FCNT_HI: begin stb.rdSel = SEL_CNT_HI; stb.wrCntHi = busWr; end
          W_CNT_LO, W_FCNT_LO: begin stb.rdSel = SEL_CNT_LO; stb.wrCntLo = busWr; end
          W_CSR:     begin stb.rdSel = SEL_CSR;    stb.wrCsr    = busWr; end
          W_PACK_HI: stb.rdSel = SEL_PACK_HI;
          W_PACK_LO: stb.rdSel = SEL_PACK_LO;
          W_VECMOD:  begin stb.rdSel = SEL_VECMOD; stb.wrVecMod = busWr; end
          default:   stb.rdSel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int DMA_ADDR_W = 24,
  parameter int CNT_W      = 24,
  parameter bit BOARD_ID   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [REG_W-1:0]      busWdata,
  input  logic [7:0]            ctlRdata,
  input  logic                  ctlIrqIn,
  input  logic                  dmaIrqIn,
  input  logic                  dmaBusErrIn,
  input  logic                  dmaActiveIn,
  input  logic                  fifoFullIn,
  input  logic                  fifoEmptyIn,
  input  logic [1:0]            lobCountIn,
  input  logic [REG_W-1:0]      packHiIn,
  input  logic [REG_W-1:0]      packLoIn,
  output logic [REG_W-1:0]      rdData,
  output logic [DMA_ADDR_W-1:0] dmaAddr,
  output logic [CNT_W-1:0]      dmaCount,
  output logic [VM_W-1:0]       vecMod,
  output logic [RW_W-1:0]       csrRw,
  output logic                  conflictFlag,
  output logic                  busErrFlag,
  output logic                  irqOut
);
  localparam int ADDR_HI_W = DMA_ADDR_W - REG_W;
  localparam int CNT_HI_W  = CNT_W - REG_W;

  logic [DMA_ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]      cntQ;
  logic [VM_W-1:0]       vecModQ;
  logic [RW_W-1:0]       rwQ;
  logic                  conflictQ;
  logic                  busErrQ;
  logic                  irqQ;
  logic                  clearSticky;
  logic [REG_W-1:0]      csrView;

  assign clearSticky = stb.wrCsr & ~busWdata[B_CTLRSTN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      cntQ      <= '0;
      vecModQ   <= '0;
      rwQ       <= '0;
      conflictQ <= 1'b0;
      busErrQ   <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      if (stb.wrAddrHi) addrQ[DMA_ADDR_W-1:REG_W] <= busWdata[ADDR_HI_W-1:0];
      if (stb.wrAddrLo) addrQ[REG_W-1:0]          <= busWdata;
      if (stb.wrCntHi)  cntQ[CNT_W-1:REG_W]       <= busWdata[CNT_HI_W-1:0];
      if (stb.wrCntLo)  cntQ[REG_W-1:0]           <= busWdata;
      if (stb.wrVecMod) vecModQ <= busWdata[VM_W-1:0];
      if (stb.wrCsr)    rwQ     <= busWdata[RW_W-1:0];
      if (stb.setConflict)  conflictQ <= 1'b1;
      else if (clearSticky) conflictQ <= 1'b0;
      if (dmaBusErrIn)      busErrQ <= 1'b1;
      else if (clearSticky) busErrQ <= 1'b0;
      irqQ <= rwQ[B_INTEN] &
              ((ctlIrqIn & rwQ[B_DMAEN]) | dmaIrqIn | conflictQ | busErrQ);
    end
  end

  assign csrView = {dmaActiveIn, conflictQ, busErrQ, BOARD_ID, fifoFullIn,
                    fifoEmptyIn, ctlIrqIn, dmaIrqIn, lobCountIn, rwQ};

  always_comb begin
    case (stb.rdSel)
      SEL_CTL:     rdData = {8'h00, ctlRdata};
      SEL_ADDR_HI: rdData = REG_W'(addrQ[DMA_ADDR_W-1:REG_W]);
      SEL_ADDR_LO: rdData = addrQ[REG_W-1:0];
      SEL_CNT_HI:  rdData = REG_W'(cntQ[CNT_W-1:REG_W]);
      SEL_CNT_LO:  rdData = cntQ[REG_W-1:0];
      SEL_CSR:     rdData = csrView;
      SEL_PACK_HI: rdData = packHiIn;
      SEL_PACK_LO: rdData = packLoIn;
      SEL_VECMOD:  rdData = REG_W'(vecModQ);
      default:     rdData = '0;
    endcase
  end

  assign dmaAddr      = addrQ;
  assign dmaCount     = cntQ;
  assign vecMod       = vecModQ;
  assign csrRw        = rwQ;
  assign conflictFlag = conflictQ;
  assign busErrFlag   = busErrQ;
  assign irqOut       = irqQ;
endmodule

// File: rtl/scsi_adapter_regs.sv
module scsi_adapter_regs
  import sar_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REGION_BITS = 11,
  parameter int REGION_TAG  = 0,
  parameter int DMA_ADDR_W  = 24,
  parameter int CNT_W       = 24,
  parameter bit BOARD_ID    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [15:0]           busWdata,
  output logic [15:0]           busRdata,
  output logic                  busHit,
  output logic                  ctlSel,
  output logic                  ctlWr,
  output logic                  ctlRd,
  output logic [2:0]            ctlIdx,
  output logic [7:0]            ctlWdata,
  input  logic [7:0]            ctlRdata,
  input  logic                  ctlIrqIn,
  input  logic                  dmaIrqIn,
  input  logic                  dmaBusErrIn,
  input  logic                  dmaActiveIn,
  input  logic                  fifoFullIn,
  input  logic                  fifoEmptyIn,
  input  logic [1:0]            lobCountIn,
  input  logic [15:0]           packHiIn,
  input  logic [15:0]           packLoIn,
  output logic [DMA_ADDR_W-1:0] dmaAddr,
  output logic [CNT_W-1:0]      dmaCount,
  output logic [7:0]            vecOut,
  output logic [5:0]            addrModOut,
  output logic                  packCtlOut,
  output logic                  dmaEnOut,
  output logic                  sendOut,
  output logic                  fifoResetN,
  output logic                  ctlResetN,
  output logic                  irqOut
);
  strobe_t          stb;
  logic [REG_W-1:0] rdData;
  logic [VM_W-1:0]  vecMod;
  logic [RW_W-1:0]  csrRw;
  logic             conflictFlag;
  logic             busErrFlag;

  sar_decode #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .REGION_TAG(REGION_TAG)
  ) decode_i (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .dmaEn(csrRw[B_DMAEN]),
    .busHit(busHit), .ctlSel(ctlSel), .ctlWr(ctlWr), .ctlRd(ctlRd),
    .ctlIdx(ctlIdx), .stb(stb)
  );

  sar_datapath #(
    .DMA_ADDR_W(DMA_ADDR_W), .CNT_W(CNT_W), .BOARD_ID(BOARD_ID)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .ctlRdata(ctlRdata),
    .ctlIrqIn(ctlIrqIn), .dmaIrqIn(dmaIrqIn), .dmaBusErrIn(dmaBusErrIn),
    .dmaActiveIn(dmaActiveIn), .fifoFullIn(fifoFullIn), .fifoEmptyIn(fifoEmptyIn),
    .lobCountIn(lobCountIn), .packHiIn(packHiIn), .packLoIn(packLoIn),
    .rdData(rdData), .dmaAddr(dmaAddr), .dmaCount(dmaCount), .vecMod(vecMod),
    .csrRw(csrRw), .conflictFlag(conflictFlag), .busErrFlag(busErrFlag),
    .irqOut(irqOut)
  );

  assign busRdata   = (busRd & busHit) ? rdData : '0;
  assign ctlWdata   = busWdata[7:0];
  assign vecOut     = vecMod[7:0];
  assign addrModOut = vecMod[13:8];
  assign packCtlOut = csrRw[B_PACK];
  assign dmaEnOut   = csrRw[B_DMAEN];
  assign sendOut    = csrRw[B_SEND];
  assign fifoResetN = csrRw[B_FIFORSTN];
  assign ctlResetN  = csrRw[B_CTLRSTN];
endmodule

// File: rtl/sar_checker.sv
module sar_checker
  import sar_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int REGION_BITS = 11,
  parameter int REGION_TAG  = 0,
  parameter int CNT_W       = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWdata,
  input logic              busHit,
  input logic              ctlSel,
  input logic              ctlIrqIn,
  input logic              dmaIrqIn,
  input logic [CNT_W-1:0]  dmaCount,
  input logic              irqOut,
  input strobe_t           stb,
  input logic [RW_W-1:0]   csrRw,
  input logic              conflictFlag,
  input logic              busErrFlag
);
  localparam int TAG_W = ADDR_W - REGION_BITS;

  p_region_tag_r1: assert property (@(posedge clk) disable iff (!rstN)
    busHit |-> busAddr[ADDR_W-1:REGION_BITS] == TAG_W'(REGION_TAG));

  p_ctl_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctlSel |-> (busHit && busAddr[4:3] == 2'b00));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrCntHi || stb.wrCntLo) |=> $stable(dmaCount));

  p_conflict_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctlSel && csrRw[B_DMAEN]) |=> conflictFlag);

  p_conflict_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (conflictFlag && !(stb.wrCsr && !busWdata[B_CTLRSTN])) |=> conflictFlag);

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(csrRw[B_INTEN] && ((ctlIrqIn && csrRw[B_DMAEN]) ||
                             dmaIrqIn || conflictFlag || busErrFlag)));

  p_ctl_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!csrRw[B_DMAEN] && !dmaIrqIn && !conflictFlag && !busErrFlag) |=> !irqOut);
endmodule

bind scsi_adapter_regs sar_checker #(
  .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS), .REGION_TAG(REGION_TAG), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busHit(busHit),
  .ctlSel(ctlSel), .ctlIrqIn(ctlIrqIn), .dmaIrqIn(dmaIrqIn), .dmaCount(dmaCount),
  .irqOut(irqOut), .stb(stb), .csrRw(csrRw), .conflictFlag(conflictFlag),
  .busErrFlag(busErrFlag)
);

// File: tb/scsi_adapter_regs_tb_top.sv
`timescale 1ns/1ps
module scsi_adapter_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        busHit, ctlSel, ctlWr, ctlRd;
  logic [2:0]  ctlIdx;
  logic [7:0]  ctlWdata;
  logic [7:0]  ctlRdata = 8'h5A;
  logic        ctlIrqIn = 1'b0, dmaIrqIn = 1'b0, dmaBusErrIn = 1'b0;
  logic        dmaActiveIn = 1'b1, fifoFullIn = 1'b0, fifoEmptyIn = 1'b1;
  logic [1:0]  lobCountIn = 2'b10;
  logic [15:0] packHiIn = 16'hA1B2, packLoIn = 16'hC3D4;
  logic [23:0] dmaAddr, dmaCount;
  logic [7:0]  vecOut;
  logic [5:0]  addrModOut;
  logic        packCtlOut, dmaEnOut, sendOut, fifoResetN, ctlResetN, irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  scsi_adapter_regs dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .busHit(busHit), .ctlSel(ctlSel),
    .ctlWr(ctlWr), .ctlRd(ctlRd), .ctlIdx(ctlIdx), .ctlWdata(ctlWdata),
    .ctlRdata(ctlRdata), .ctlIrqIn(ctlIrqIn), .dmaIrqIn(dmaIrqIn),
    .dmaBusErrIn(dmaBusErrIn), .dmaActiveIn(dmaActiveIn), .fifoFullIn(fifoFullIn),
    .fifoEmptyIn(fifoEmptyIn), .lobCountIn(lobCountIn), .packHiIn(packHiIn),
    .packLoIn(packLoIn), .dmaAddr(dmaAddr), .dmaCount(dmaCount), .vecOut(vecOut),
    .addrModOut(addrModOut), .packCtlOut(packCtlOut), .dmaEnOut(dmaEnOut),
    .sendOut(sendOut), .fifoResetN(fifoResetN), .ctlResetN(ctlResetN), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isRead;
    logic [15:0] addr;
    logic [15:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 31;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0008, 16'h12AB, 4'd0}, '{1'b1, 16'h0008, 16'h00AB, 4'd3},
    '{1'b0, 16'h000A, 16'hBEEF, 4'd0}, '{1'b1, 16'h000A, 16'hBEEF, 4'd3},
    '{1'b1, 16'h002A, 16'hBEEF, 4'd1}, '{1'b1, 16'h07EA, 16'hBEEF, 4'd1},
    '{1'b0, 16'h000E, 16'h1234, 4'd0}, '{1'b1, 16'h0010, 16'h1234, 4'd4},
    '{1'b0, 16'h0010, 16'h5678, 4'd0}, '{1'b1, 16'h000E, 16'h5678, 4'd4},
    '{1'b0, 16'h001A, 16'h0077, 4'd0}, '{1'b1, 16'h000C, 16'h0077, 4'd4},
    '{1'b0, 16'h000C, 16'hFF99, 4'd0}, '{1'b1, 16'h001A, 16'h0099, 4'd4},
    '{1'b0, 16'h0018, 16'hFFFF, 4'd0}, '{1'b1, 16'h0018, 16'h3FFF, 4'd9},
    '{1'b0, 16'h001C, 16'h1111, 4'd0}, '{1'b0, 16'h001E, 16'h2222, 4'd0},
    '{1'b1, 16'h001C, 16'h0000, 4'd12}, '{1'b1, 16'h001E, 16'h0000, 4'd12},
    '{1'b1, 16'h000A, 16'hBEEF, 4'd12}, '{1'b1, 16'h0010, 16'h5678, 4'd12},
    '{1'b0, 16'h0012, 16'h0026, 4'd0}, '{1'b1, 16'h0012, 16'h94A6, 4'd6},
    '{1'b0, 16'h0012, 16'hFFC0, 4'd0}, '{1'b1, 16'h0012, 16'h9480, 4'd5},
    '{1'b1, 16'h0014, 16'hA1B2, 4'd12}, '{1'b1, 16'h0016, 16'hC3D4, 4'd12},
    '{1'b1, 16'h0003, 16'h005A, 4'd2},
    '{1'b0, 16'h080A, 16'hDEAD, 4'd0}, '{1'b1, 16'h000A, 16'hBEEF, 4'd1}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd9: return "R9";   4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [15:0] d, output logic h);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1; d = busRdata; h = busHit;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d;
    logic h;
    busRead(a, d, h);
    check(req, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state: control bits zero (resets asserted), registers zero
    check("R6 reset", {26'h0, packCtlOut, dmaEnOut, sendOut, fifoResetN, ctlResetN, irqOut}, 32'h0);
    check("R3 reset", {8'h0, dmaAddr}, 32'h0);
    check("R4 reset", {8'h0, dmaCount}, 32'h0);
    readCheck("R5 reset", 16'h0012, 16'h9480);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isRead) readCheck(reqName(VECS[i].req), VECS[i].addr, VECS[i].data);
      else busWrite(VECS[i].addr, VECS[i].data);
    end
    check("R3 pins", {8'h0, dmaAddr}, 32'h00ABBEEF);
    check("R4 pins", {8'h0, dmaCount}, 32'h00995678);
    check("R9 pins", {18'h0, addrModOut, vecOut}, 32'h00003FFF);

    // R2: controller strobes in the access cycle
    @(negedge clk); busAddr = 16'h0005; busWdata = 16'h00C7; busWr = 1'b1;
    #1;
    check("R2 strobes", {20'h0, ctlSel, ctlWr, ctlRd, ctlIdx, ctlWdata}, {20'h0, 1'b1, 1'b1, 1'b0, 3'd5, 8'hC7});
    @(negedge clk); busWr = 1'b0;
    // R7: that access with DMA disabled set no conflict
    readCheck("R7 no conflict", 16'h0012, 16'h9480);

    // R7: access with DMA enabled
    busWrite(16'h0012, 16'h0017);
    busWrite(16'h0001, 16'h0000);
    readCheck("R7 conflict", 16'h0012, 16'hD497);
    settle();
    check("R10 conflict irq", {31'h0, irqOut}, 32'h1);

    // R8: stickiness and clearing
    busWrite(16'h0012, 16'h0017);
    readCheck("R8 hold", 16'h0012, 16'hD497);
    busWrite(16'h0012, 16'h0016);
    readCheck("R8 clear", 16'h0012, 16'h9496);
    @(negedge clk); dmaBusErrIn = 1'b1;
    @(negedge clk); dmaBusErrIn = 1'b0;
    readCheck("R8 buserr", 16'h0012, 16'hB496);
    settle();
    check("R10 buserr irq", {31'h0, irqOut}, 32'h1);
    busWrite(16'h0012, 16'h0006);
    readCheck("R8 buserr clear", 16'h0012, 16'h9486);
    settle();
    check("R10 idle irq", {31'h0, irqOut}, 32'h0);

    // R11: controller interrupt gated by DMA enable
    ctlIrqIn = 1'b1;
    readCheck("R5 ctl pending", 16'h0012, 16'h9686);
    settle();
    check("R11 gated", {31'h0, irqOut}, 32'h0);
    busWrite(16'h0012, 16'h0017);
    settle();
    check("R11 passed", {31'h0, irqOut}, 32'h1);
    ctlIrqIn = 1'b0;
    settle();
    check("R10 drop", {31'h0, irqOut}, 32'h0);

    // R10: DMA interrupt and interrupt enable
    busWrite(16'h0012, 16'h0007);
    dmaIrqIn = 1'b1;
    settle();
    check("R10 dma irq", {31'h0, irqOut}, 32'h1);
    busWrite(16'h0012, 16'h0003);
    settle();
    check("R10 masked", {31'h0, irqOut}, 32'h0);
    dmaIrqIn = 1'b0;

    // R6: control pins
    busWrite(16'h0012, 16'h003F);
    check("R6 all set", {27'h0, packCtlOut, dmaEnOut, sendOut, fifoResetN, ctlResetN}, 32'h1F);
    busWrite(16'h0012, 16'h002A);
    check("R6 pattern", {27'h0, packCtlOut, dmaEnOut, sendOut, fifoResetN, ctlResetN}, 32'h16);

    // R1: region probe
    busRead(16'h0803, d, h);
    check("R1 probe miss", {15'h0, h, d}, 32'h0);
    busRead(16'h0003, d, h);
    check("R1 hit", {15'h0, h, d}, {15'h0, 1'b1, 16'h005A});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule